// File: doc/BRIEF.md
# GPIO Port Register File

This block is a memory-mapped port of 32 general-purpose pins behind a plain 32-bit register bus. Each pin has an output-enable bit and an output-value bit. The block drives both onto the pad signals, and it brings the pad input levels back through a synchroniser so that software can read them.

Software never writes the direction vector as a whole. One register sets the direction bits that are written as one, and a second register clears them. Output values are written one half of the port at a time. In that write the upper half-word is a per-bit mask and the lower half-word holds the new levels. A value can be loaded while its pin is still an input, and it is driven the moment the pin's enable turns on.

A bus access is a single cycle with `busSel` high. Writes take effect at that clock edge. `busReady` and any read data appear in the following cycle. Only exact byte offsets decode.

Top module: `gpioPortRegs`

## Requirements
- R1: After reset, `padOutEn` and `padOut` are all zero, `busReady` is low, and reads of offsets 0x04, 0x08 and 0x0C return zero.
- R2: A write to offset 0x00 sets the output enable of every pin whose data bit is one. Pins whose data bit is zero keep their enable.
- R3: A write to offset 0x04 clears the output enable of every pin whose data bit is one. Pins whose data bit is zero keep their enable. A read of 0x04 returns the enable vector, and a read of 0x00 returns zero.
- R4: A write to offset 0x08 updates pin n (n from 0 to 15) to data bit n only where data bit n+16 is one. Every other output value is unchanged.
- R5: A write to offset 0x0C updates pin 16+n (n from 0 to 15) to data bit n only where data bit n+16 is one. Every other output value is unchanged.
- R6: A read of 0x08 returns the output values of pins 0 to 15 in bits 15:0, with zero in bits 31:16. A read of 0x0C returns pins 16 to 31 in the same way.
- R7: A read of 0x10 returns the pad levels after a two-flop synchroniser. Let the edge that first samples a new level be edge k. A read captured at edge k+2 or later shows that level, and reads captured at edges k and k+1 show the old level.
- R8: `padOut` always carries the stored output values, whatever the direction. When a pin's enable rises, its `padOut` value in that same cycle is the value it held before.
- R9: Accesses to any other offset, unaligned bytes included, read as zero and change no state.
- R10: `busReady` is high exactly in the cycle after a cycle with `busSel` high. For a read, `busRdData` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request for this cycle |
| busWrEn | input | 1 | Access is a write when high |
| busAddr | input | 8 | Byte offset of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completed |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOut | output | 32 | Output value per pin |
| padOutEn | output | 32 | Output enable per pin (1 = drive) |

## Verification
Two functions can meet in one cycle: a change of pad input level and a bus read of the input register. The bench changes `padIn` in the same cycle in which it issues a read of 0x10. It then reads back to back, and each result is judged against a two-stage delay model of the pad history. A directed run pins down the exact edge at which the new level first appears. A second overlap is the preload case: an output value is written while the pin is an input, and the pin is then switched to output. The bench checks that the pad value in the first enabled cycle equals the value loaded earlier.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;

  localparam logic [7:0] OFS_DIR_SET = 8'h00;
  localparam logic [7:0] OFS_DIR_CLR = 8'h04;
  localparam logic [7:0] OFS_OUT_LO  = 8'h08;
  localparam logic [7:0] OFS_OUT_HI  = 8'h0C;
  localparam logic [7:0] OFS_PINS    = 8'h10;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_DIR,
    RD_OUT_LO,
    RD_OUT_HI,
    RD_PINS
  } rdSel_e;

  typedef struct packed {
    logic       setDir;
    logic       clrDir;
    logic [1:0] wrHalf;
    logic       rdEn;
    rdSel_e     rdSel;
  } ctrlStb_t;

endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStb_t          stb,
  output logic              busReady
);

  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_DIR_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_DIR_CLR);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_OUT_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_OUT_HI);
  localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(OFS_PINS);

  always_comb begin
    stb = '0;
    stb.rdSel = RD_ZERO;
    if (busSel) begin
      if (busWrEn) begin
        case (busAddr)
          A_SET:   stb.setDir    = 1'b1;
          A_CLR:   stb.clrDir    = 1'b1;
          A_LO:    stb.wrHalf[0] = 1'b1;
          A_HI:    stb.wrHalf[1] = 1'b1;
          default: ;
        endcase
      end else begin
        stb.rdEn = 1'b1;
        case (busAddr)
          A_CLR:   stb.rdSel = RD_DIR;
          A_LO:    stb.rdSel = RD_OUT_LO;
          A_HI:    stb.rdSel = RD_OUT_HI;
          A_PINS:  stb.rdSel = RD_PINS;
          default: stb.rdSel = RD_ZERO;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= busSel;
  end

  // R10: ready follows a request by exactly one cycle
  assert_ready_after_sel_R10: assert property (@(posedge clk) disable iff (!rstN)
    busSel |=> busReady);
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> !busReady);
  // R9: a write to an unmapped offset raises no write strobe
  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrEn && busAddr != A_SET && busAddr != A_CLR &&
     busAddr != A_LO && busAddr != A_HI) |-> !(stb.setDir || stb.clrDir || (|stb.wrHalf)));

endmodule

// File: rtl/gpioPortDatapath.sv
module gpioPortDatapath
  import gpioPortPkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] oeVec,
  output logic [NUM_PINS-1:0] outVec,
  output logic [NUM_PINS-1:0] rdData
);

  localparam int HALF_W = NUM_PINS / 2;

  logic [HALF_W-1:0]   wrMask;
  logic [HALF_W-1:0]   wrVal;
  logic [NUM_PINS-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinLevel;
  logic [NUM_PINS-1:0] rdNext;

  assign wrMask = wrData[NUM_PINS-1:HALF_W];
  assign wrVal  = wrData[HALF_W-1:0];

  // Direction: separate set and clear strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           oeVec <= '0;
    else if (stb.setDir) oeVec <= oeVec | wrData;
    else if (stb.clrDir) oeVec <= oeVec & ~wrData;
  end

  // Output values: one masked register per half of the port
  for (genvar h = 0; h < 2; h++) begin : gHalf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        outVec[h*HALF_W +: HALF_W] <= '0;
      else if (stb.wrHalf[h])
        outVec[h*HALF_W +: HALF_W] <= (outVec[h*HALF_W +: HALF_W] & ~wrMask) | (wrVal & wrMask);
    end

    // R4 / R5: bits outside the mask keep their value
    assert_half_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      stb.wrHalf[h] |=> ((outVec[h*HALF_W +: HALF_W] ^ $past(outVec[h*HALF_W +: HALF_W]))
                         & ~$past(wrMask)) == '0);
    // R5: the other half is untouched by this half's write
    assert_half_isolated_R5: assert property (@(posedge clk) disable iff (!rstN)
      !stb.wrHalf[h] |=> $stable(outVec[h*HALF_W +: HALF_W]));
  end

  // Pad synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncPipe[k] <= '0;
    end else begin
      syncPipe[0] <= padIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncPipe[k] <= syncPipe[k-1];
    end
  end
  assign pinLevel = syncPipe[SYNC_STAGES-1];

  always_comb begin
    case (stb.rdSel)
      RD_DIR:    rdNext = oeVec;
      RD_OUT_LO: rdNext = {{HALF_W{1'b0}}, outVec[HALF_W-1:0]};
      RD_OUT_HI: rdNext = {{HALF_W{1'b0}}, outVec[NUM_PINS-1:HALF_W]};
      RD_PINS:   rdNext = pinLevel;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
    else               rdData <= '0;
  end

  // R2: every bit written as one is enabled afterwards
  assert_dir_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setDir |=> (oeVec & $past(wrData)) == $past(wrData));
  // R3: every bit written as one is disabled afterwards
  assert_dir_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrDir |=> (oeVec & $past(wrData)) == '0);
  // R9: without a direction strobe the enables hold
  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setDir || stb.clrDir) |=> $stable(oeVec));
  // R6: the mask half of an output read-back is zero
  assert_rd_mask_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && (stb.rdSel == RD_OUT_LO || stb.rdSel == RD_OUT_HI))
      |=> rdData[NUM_PINS-1:HALF_W] == '0);

endmodule

// File: rtl/gpioPortRegs.sv
module gpioPortRegs
  import gpioPortPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  output logic                busReady,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn
);

  ctrlStb_t stb;

  gpioPortCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .stb      (stb),
    .busReady (busReady)
  );

  gpioPortDatapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (busWrData),
    .padIn  (padIn),
    .oeVec  (padOutEn),
    .outVec (padOut),
    .rdData (busRdData)
  );

  // R8: a pin that just turned on drives the value it held before
  assert_preload_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((padOutEn & ~$past(padOutEn)) & (padOut ^ $past(padOut))) == '0);
  // R1: nothing is driven or reported as ready while in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (padOutEn == '0 && padOut == '0 && !busReady));

endmodule

// File: tb/gpioPortRegs_test.sv
module gpioPortRegs_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWrEn;
  logic [7:0]  busAddr;
  logic [31:0] busWrData, busRdData, padIn, padOut, padOutEn;
  logic        busReady;

  always #10 clk = ~clk;

  gpioPortRegs uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busReady(busReady), .padIn(padIn), .padOut(padOut), .padOutEn(padOutEn)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mOe, mOut, pipe1, pipe2;

  // two-stage delay model of the pad history (R7)
  always @(posedge clk) begin
    if (!rstN) begin
      pipe1 <= '0;
      pipe2 <= '0;
    end else begin
      pipe2 <= pipe1;
      pipe1 <= padIn;
    end
  end

  function automatic logic [15:0] maskMerge(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h04:   return mOe;
      8'h08:   return {16'h0, mOut[15:0]};
      8'h0C:   return {16'h0, mOut[31:16]};
      8'h10:   return pipe2;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic access(string req, logic [7:0] a, logic we, logic [31:0] d);
    logic [31:0] exp;
    exp = expRead(a);
    busSel = 1'b1; busWrEn = we; busAddr = a; busWrData = d;
    @(posedge clk);
    if (we) begin
      case (a)
        8'h00: mOe = mOe | d;
        8'h04: mOe = mOe & ~d;
        8'h08: mOut[15:0]  = maskMerge(mOut[15:0], d);
        8'h0C: mOut[31:16] = maskMerge(mOut[31:16], d);
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R10 ready", {31'h0, busReady}, 32'h1);
    if (!we) chk(req, busRdData, exp);
    chk({req, " padOutEn"}, padOutEn, mOe);
    chk({req, " padOut"}, padOut, mOut);
    busSel = 1'b0;
  endtask

  task automatic readExpect(string req, logic [7:0] a, logic [31:0] lit);
    access(req, a, 1'b0, 32'h0);
    chk({req, " literal"}, busRdData, lit);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] badAddr [5];
    void'($urandom(32'd20240611));
    badAddr[0] = 8'h01; badAddr[1] = 8'h14; badAddr[2] = 8'h20;
    badAddr[3] = 8'hFC; badAddr[4] = 8'h0A;
    rstN = 1'b0; busSel = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    padIn = '0; mOe = '0; mOut = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 padOutEn", padOutEn, 32'h0);
    chk("R1 padOut", padOut, 32'h0);
    chk("R1 ready", {31'h0, busReady}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readExpect("R1 dir", 8'h04, 32'h0);
    readExpect("R1 outlo", 8'h08, 32'h0);
    readExpect("R1 outhi", 8'h0C, 32'h0);

    // R2: set only where ones are written
    access("R2 set", 8'h00, 1'b1, 32'h0000_00F0);
    access("R2 set", 8'h00, 1'b1, 32'h0000_0003);
    chk("R2 literal", padOutEn, 32'h0000_00F3);
    // R3: clear only where ones are written, read-back
    access("R3 clr", 8'h04, 1'b1, 32'h0000_0021);
    chk("R3 literal", padOutEn, 32'h0000_00D2);
    readExpect("R3 dir read", 8'h04, 32'h0000_00D2);
    readExpect("R3 set-reg read", 8'h00, 32'h0);

    // R4 / R6: masked low half
    access("R4 lo", 8'h08, 1'b1, 32'h00FF_1234);
    access("R4 lo", 8'h08, 1'b1, 32'hFF00_ABCD);
    readExpect("R6 lo read", 8'h08, 32'h0000_AB34);
    // R5 / R6: masked high half
    access("R5 hi", 8'h0C, 1'b1, 32'hFFFF_5A5A);
    access("R5 hi", 8'h0C, 1'b1, 32'h000F_FFFF);
    readExpect("R6 hi read", 8'h0C, 32'h0000_5A5F);
    chk("R5 literal", padOut, 32'h5A5F_AB34);

    // R8: preload while input, then enable
    access("R8 clr all", 8'h04, 1'b1, 32'hFFFF_FFFF);
    access("R8 preload", 8'h08, 1'b1, 32'h0004_0000);
    chk("R8 preload value", padOut, 32'h5A5F_AB30);
    access("R8 enable", 8'h00, 1'b1, 32'h0000_0005);
    chk("R8 enabled", padOutEn, 32'h0000_0005);
    chk("R8 value kept", padOut, 32'h5A5F_AB30);
    access("R8 drive one", 8'h08, 1'b1, 32'h0004_0004);
    chk("R8 drive one literal", padOut, 32'h5A5F_AB34);

    // R9: unmapped offsets
    for (int i = 0; i < 5; i++) begin
      access("R9 bad write", badAddr[i], 1'b1, 32'hFFFF_FFFF);
      readExpect("R9 bad read", badAddr[i], 32'h0);
    end
    readExpect("R9 dir unchanged", 8'h04, 32'h0000_0005);

    // R7: exact synchroniser latency, pad change coinciding with a read
    padIn = 32'hA5A5_0F0F;
    repeat (4) @(negedge clk);
    padIn = 32'h1234_8765;
    readExpect("R7 edge k", 8'h10, 32'hA5A5_0F0F);
    readExpect("R7 edge k+1", 8'h10, 32'hA5A5_0F0F);
    readExpect("R7 edge k+2", 8'h10, 32'h1234_8765);

    // R10: idle cycle drops ready
    @(negedge clk);
    chk("R10 idle", {31'h0, busReady}, 32'h0);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] d;
      if (($urandom % 4) == 0) padIn = $urandom;
      op = $urandom % 7;
      d = $urandom;
      case (op)
        0: access("R2 rnd", 8'h00, 1'b1, d);
        1: access("R3 rnd", 8'h04, 1'b1, d);
        2: access("R4 rnd", 8'h08, 1'b1, d);
        3: access("R5 rnd", 8'h0C, 1'b1, d);
        4: begin
          logic [7:0] ra;
          ra = 8'(($urandom % 5) * 4);
          access("R6 R7 rnd read", ra, 1'b0, 32'h0);
        end
        5: access("R7 rnd pins", 8'h10, 1'b0, 32'h0);
        default: access("R9 rnd bad", badAddr[$urandom % 5], ($urandom % 2) == 1, d);
      endcase
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        chk("R10 rnd idle", {31'h0, busReady}, 32'h0);
      end
    end

    finishRun();
  end

endmodule